// File: doc/BRIEF.md
# UART register front end

A memory-mapped serial port core with three 32-bit registers. Software sends a character by writing it together with a launch flag into the data register, and it collects a received character from the same register by reading it and then writing an acknowledge flag back. Each direction has room for one character. Behind the holding slots sit a start/8-data/stop serializer and deserializer. Both are paced by a one-cycle baud tick that an external rate generator supplies. The rate generator's scale and step settings are kept in the clock register and driven out on ports.

A control register selects an interface mode. Mode 0 switches the core off. The other modes choose which of two handshake inputs gates each direction. Two override bits let either direction run without regard to its handshake input. A receive overrun is recorded in a sticky flag.

Top module: `uart_regfront`

## Requirements
- R1: After reset the data register (offset 0x0) reads 0x200, the control register (offset 0x4) and the clock register (offset 0x8) read 0, an unmapped offset (0xC) reads 0, and txd is 1.
- R2: A write to the clock register stores bits [27:16] as the scale and bits [15:0] as the step. Both read back in place and drive baud_scale and baud_step. Bits [31:28] read 0.
- R3: Bit 9 of the data register reads 1 while the transmit slot is empty. A write to the data register with bit 9 set and the slot empty queues bits [7:0], and bit 9 then reads 0 until the serializer takes the character. A write with bit 9 clear queues nothing.
- R4: A queued character leaves on txd as one 0 start bit, 8 data bits LSB first, and one 1 stop bit. Each bit lasts exactly one baud-tick period and the first bit starts on a tick.
- R5: When a frame with a valid stop bit completes, bit 8 of the data register reads 1 and bits [7:0] hold the character. Writing the data register with bit 8 set clears bit 8. While bit 8 is 0, bits [7:0] read 0.
- R6: A frame that completes while bit 8 is set is dropped, the held character is kept, and the sticky overrun flag at control bit 4 is set. Writing 1 to control bit 4 clears the flag.
- R7: While control bits [3:2] are 0 the core is disabled. txd stays 1, a queued character waits in its slot, and activity on rxd delivers nothing.
- R8: With mode 1 the transmitter is gated by hs_in[0] and the receiver by hs_in[1]. With mode 2 or 3 the transmitter is gated by hs_in[1] and the receiver by hs_in[0]. A gated-off transmitter does not launch, and a gated-off receiver ignores start bits.
- R9: Control bit 7 set lets the transmitter launch regardless of its handshake input. Control bit 8 set does the same for the receiver.
- R10: A frame whose stop bit samples as 0 is discarded and leaves bit 8 unchanged.
- R11: The control register reads back bits [3:2], 7 and 8 as written, bit 4 as the overrun flag, and all other bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| baud_scale | output | 12 | Scale setting for the rate generator |
| baud_step | output | 16 | Step setting for the rate generator |
| hs_in | input | 2 | Handshake inputs routed by interface mode |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The assertions check the following on every cycle: txd returns high whenever the core is disabled, a queued character blocks the ready flag, the serializer never launches without its gate, a dropped frame raises the overrun flag and the flag persists until cleared, and an acknowledge empties the slot while an unacknowledged character stays unchanged. Only the bench scenarios can show the bit order and one-tick bit timing of whole frames in both directions, the handshake routing for each interface mode, the discarding of frames with a bad stop bit, and the register readback layout. It does this with full sweeps over all 256 character values in both directions.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int CHAR_W  = 8;
  localparam int SCALE_W = 12;
  localparam int STEP_W  = 16;

  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 4;
  localparam int OFS_CLK  = 8;

  localparam int DAT_RXV     = 8;
  localparam int DAT_TXR     = 9;
  localparam int CTL_MODE_LO = 2;
  localparam int CTL_OVR     = 4;
  localparam int CTL_TXF     = 7;
  localparam int CTL_RXF     = 8;
  localparam int CLK_SCALE_LO = 16;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DTE  = 2'd1,
    MODE_DCE  = 2'd2,
    MODE_DCE2 = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  tx_force;
    logic  rx_force;
  } ctrl_t;

  function automatic logic [31:0] pack_data(logic [CHAR_W-1:0] c, logic rxv, logic txr);
    logic [31:0] w;
    w = '0;
    w[CHAR_W-1:0] = rxv ? c : '0;
    w[DAT_RXV] = rxv;
    w[DAT_TXR] = txr;
    return w;
  endfunction

  function automatic logic [31:0] pack_ctrl(ctrl_t c, logic ovr);
    logic [31:0] w;
    w = '0;
    w[CTL_MODE_LO +: 2] = c.mode;
    w[CTL_OVR] = ovr;
    w[CTL_TXF] = c.tx_force;
    w[CTL_RXF] = c.rx_force;
    return w;
  endfunction

  function automatic logic [31:0] pack_clk(logic [SCALE_W-1:0] sc, logic [STEP_W-1:0] st);
    logic [31:0] w;
    w = '0;
    w[CLK_SCALE_LO +: SCALE_W] = sc;
    w[STEP_W-1:0] = st;
    return w;
  endfunction

  // Returns {tx gate, rx gate} taken from the handshake pair for a mode.
  function automatic logic [1:0] hs_route(mode_e m, logic [1:0] hs);
    case (m)
      MODE_OFF: return 2'b00;
      MODE_DTE: return {hs[0], hs[1]};
      default:  return {hs[1], hs[0]};
    endcase
  endfunction

endpackage

// File: rtl/uart_rf_gate.sv
module uart_rf_gate
  import uart_rf_pkg::*;
(
  input  mode_e      mode,
  input  logic       tx_force,
  input  logic       rx_force,
  input  logic [1:0] hs_in,
  output logic       core_en,
  output logic       tx_ok,
  output logic       rx_ok
);
  logic [1:0] routed;

  assign routed  = hs_route(mode, hs_in);
  assign core_en = (mode != MODE_OFF);
  assign tx_ok   = core_en && (tx_force || routed[1]);
  assign rx_ok   = core_en && (rx_force || routed[0]);
endmodule

// File: rtl/uart_rf_tx.sv
module uart_rf_tx #(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             go,
  input  logic [DBITS-1:0] char_in,
  output logic             take,
  output logic             txd
);
  localparam int CW = $clog2(DBITS + 2);
  localparam logic [CW-1:0] STOP_IDX = CW'(DBITS);

  logic             busy;
  logic [CW-1:0]    idx;
  logic [DBITS-1:0] sh;

  assign take = en && tick && go && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      sh   <= '0;
      txd  <= 1'b1;
    end else if (!en) begin
      busy <= 1'b0;
      idx  <= '0;
      txd  <= 1'b1;
    end else if (take) begin
      busy <= 1'b1;
      idx  <= '0;
      sh   <= char_in;
      txd  <= 1'b0;
    end else if (busy && tick) begin
      if (idx < STOP_IDX) begin
        txd <= sh[0];
        sh  <= sh >> 1;
        idx <= idx + 1'b1;
      end else if (idx == STOP_IDX) begin
        txd <= 1'b1;
        idx <= idx + 1'b1;
      end else begin
        busy <= 1'b0;
        idx  <= '0;
      end
    end
  end
endmodule

// File: rtl/uart_rf_rx.sv
module uart_rf_rx #(
  parameter int DBITS = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             ok,
  input  logic             rxd,
  output logic             done,
  output logic [DBITS-1:0] char_out
);
  localparam int CW = $clog2(DBITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(DBITS);

  logic [SYNC-1:0]  sync_q;
  logic             line;
  logic             busy;
  logic [CW-1:0]    idx;
  logic [DBITS-1:0] sh;
  logic             start;

  assign line  = sync_q[SYNC-1];
  assign start = en && tick && ok && !busy && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      sh       <= '0;
      done     <= 1'b0;
      char_out <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy && tick) begin
        if (idx < LAST_IDX) begin
          sh  <= {line, sh[DBITS-1:1]};
          idx <= idx + 1'b1;
        end else begin
          busy <= 1'b0;
          idx  <= '0;
          if (line) begin
            done     <= 1'b1;
            char_out <= sh;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rf_regs.sv
module uart_rf_regs
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              rx_done,
  input  logic [CHAR_W-1:0] rx_char_in,
  input  logic              tx_take,
  output logic [CHAR_W-1:0] tx_char,
  output logic              tx_full,
  output logic              rx_full,
  output logic [CHAR_W-1:0] rx_held,
  output ctrl_t             ctrl,
  output logic              overrun,
  output logic [SCALE_W-1:0] scale,
  output logic [STEP_W-1:0] step,
  output logic              tx_queue,
  output logic              rx_ack,
  output logic              rx_drop,
  output logic              ovr_clr
);
  logic hit_data, hit_ctrl, hit_clk;
  logic wr_data, wr_ctrl, wr_clk;
  logic unused_hi;

  assign hit_data = (addr == ADDR_W'(OFS_DATA));
  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_clk  = (addr == ADDR_W'(OFS_CLK));
  assign wr_data  = wr_en && hit_data;
  assign wr_ctrl  = wr_en && hit_ctrl;
  assign wr_clk   = wr_en && hit_clk;
  assign unused_hi = ^wdata[31:28];

  assign tx_queue = wr_data && wdata[DAT_TXR] && !tx_full;
  assign rx_ack   = wr_data && wdata[DAT_RXV];
  assign rx_drop  = rx_done && rx_full && !rx_ack;
  assign ovr_clr  = wr_ctrl && wdata[CTL_OVR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_char <= '0;
    end else if (tx_queue) begin
      tx_full <= 1'b1;
      tx_char <= wdata[CHAR_W-1:0];
    end else if (tx_take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_held <= '0;
    end else if (rx_done && !rx_drop) begin
      rx_full <= 1'b1;
      rx_held <= rx_char_in;
    end else if (rx_ack) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (rx_drop) overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '{mode: MODE_OFF, tx_force: 1'b0, rx_force: 1'b0};
    end else if (wr_ctrl) begin
      ctrl.mode     <= mode_e'(wdata[CTL_MODE_LO +: 2]);
      ctrl.tx_force <= wdata[CTL_TXF];
      ctrl.rx_force <= wdata[CTL_RXF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale <= '0;
      step  <= '0;
    end else if (wr_clk) begin
      scale <= wdata[CLK_SCALE_LO +: SCALE_W];
      step  <= wdata[STEP_W-1:0];
    end
  end

  always_comb begin
    if (hit_data)      rdata = pack_data(rx_held, rx_full, !tx_full);
    else if (hit_ctrl) rdata = pack_ctrl(ctrl, overrun);
    else if (hit_clk)  rdata = pack_clk(scale, step);
    else               rdata = '0;
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              baud_tick,
  output logic [11:0]       baud_scale,
  output logic [15:0]       baud_step,
  input  logic [1:0]        hs_in,
  output logic              txd,
  input  logic              rxd
);
  // Named internal events, also observed by the bound checker.
  logic              core_en, tx_ok, rx_ok;
  logic              tx_take, tx_full, tx_queue;
  logic              rx_done, rx_full, rx_ack, rx_drop;
  logic              overrun, ovr_clr;
  logic [CHAR_W-1:0] tx_char, rx_char, rx_held;
  ctrl_t             ctrl;

  uart_rf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .rx_done(rx_done), .rx_char_in(rx_char), .tx_take(tx_take),
    .tx_char(tx_char), .tx_full(tx_full), .rx_full(rx_full),
    .rx_held(rx_held), .ctrl(ctrl), .overrun(overrun),
    .scale(baud_scale), .step(baud_step),
    .tx_queue(tx_queue), .rx_ack(rx_ack), .rx_drop(rx_drop),
    .ovr_clr(ovr_clr)
  );

  uart_rf_gate u_gate (
    .mode(ctrl.mode), .tx_force(ctrl.tx_force), .rx_force(ctrl.rx_force),
    .hs_in(hs_in), .core_en(core_en), .tx_ok(tx_ok), .rx_ok(rx_ok)
  );

  uart_rf_tx #(.DBITS(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(core_en), .tick(baud_tick),
    .go(tx_ok && tx_full), .char_in(tx_char), .take(tx_take), .txd(txd)
  );

  uart_rf_rx #(.DBITS(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(core_en), .tick(baud_tick),
    .ok(rx_ok), .rxd(rxd), .done(rx_done), .char_out(rx_char)
  );
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
  import uart_rf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              core_en,
  input logic              txd,
  input logic              tx_queue,
  input logic              tx_take,
  input logic              tx_ok,
  input logic              tx_full,
  input logic              rx_done,
  input logic              rx_ack,
  input logic              rx_drop,
  input logic              rx_full,
  input logic [CHAR_W-1:0] rx_held,
  input logic              overrun,
  input logic              ovr_clr
);
  p_line_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> txd);

  p_queue_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_queue |=> tx_full);

  p_no_launch_without_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_ok);

  p_launch_only_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_full);

  p_drop_sets_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> overrun);

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  p_ack_empties_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && !rx_done |=> !rx_full);

  p_held_char_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rx_ack |=> rx_full && $stable(rx_held));
endmodule

bind uart_regfront uart_regfront_chk i_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .txd(txd),
  .tx_queue(tx_queue), .tx_take(tx_take), .tx_ok(tx_ok), .tx_full(tx_full),
  .rx_done(rx_done), .rx_ack(rx_ack), .rx_drop(rx_drop), .rx_full(rx_full),
  .rx_held(rx_held), .overrun(overrun), .ovr_clr(ovr_clr)
);

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int AW         = 4;
  localparam int WD_LIMIT   = 150000;
  localparam logic [AW-1:0] A_DATA = 4'h0;
  localparam logic [AW-1:0] A_CTRL = 4'h4;
  localparam logic [AW-1:0] A_CLK  = 4'h8;
  localparam logic [31:0] RUN_CFG = 32'h188; // mode 2, both overrides

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          baud_tick = 1'b0;
  logic [11:0]   baud_scale;
  logic [15:0]   baud_step;
  logic [1:0]    hs_in = 2'b00;
  logic          txd;
  logic          rxd = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tdiv   = 0;

  uart_regfront #(.ADDR_W(AW)) i_uart_regfront (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
    .baud_scale(baud_scale), .baud_step(baud_step), .hs_in(hs_in),
    .txd(txd), .rxd(rxd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    baud_tick = (tdiv == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
  endtask

  // Watch txd for a start bit, then sample each following bit after its tick.
  task automatic expect_frame(input string req, input logic [7:0] c);
    logic [8:0] got;
    bit found;
    found = 0;
    got = '0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      #1;
      if (!txd) begin found = 1; break; end
    end
    if (!found) begin
      check({req, " start bit"}, 32'(txd), 32'h0);
    end else begin
      for (int b = 0; b < 9; b++) begin
        wait_tick();
        #1 got[b] = txd;
      end
      check({req, " frame"}, 32'(got), {23'h0, 1'b1, c});
    end
  endtask

  // Confirm txd stays idle for a span of cycles.
  task automatic expect_quiet(input string req, input int n);
    logic low;
    low = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 if (!txd) low = 1'b1;
    end
    check({req, " txd idle"}, 32'(low), 32'h0);
  endtask

  task automatic send_frame(input logic [7:0] c, input logic stopb);
    logic [9:0] bits;
    bits = {stopb, c, 1'b0};
    for (int i = 0; i < 10; i++) begin
      wait_tick();
      #1 rxd = bits[i];
    end
    wait_tick();
    #1 rxd = 1'b1;
    wait_tick();
    wait_tick();
  endtask

  initial begin
    logic [31:0] v;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(A_DATA, v); check("R1 data", v, 32'h200);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_CLK, v);  check("R1 clk", v, 32'h0);
    rd(4'hC, v);   check("R1 unmapped", v, 32'h0);
    check("R1 txd", 32'(txd), 32'h1);

    // R2: clock register layout
    wr(A_CLK, 32'hFFFF_FFFF);
    rd(A_CLK, v); check("R2 readback all ones", v, 32'h0FFF_FFFF);
    check("R2 scale out", 32'(baud_scale), 32'hFFF);
    check("R2 step out", 32'(baud_step), 32'hFFFF);
    wr(A_CLK, 32'h0123_4567);
    rd(A_CLK, v); check("R2 readback pattern", v, 32'h0123_4567);
    check("R2 scale pattern", 32'(baud_scale), 32'h123);
    check("R2 step pattern", 32'(baud_step), 32'h4567);

    // R11: control readback layout
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R11 ctrl readback", v, 32'h18C);
    wr(A_CTRL, RUN_CFG);
    rd(A_CTRL, v); check("R11 ctrl run config", v, RUN_CFG);

    // R4 / R3: exhaustive transmit sweep
    for (int c = 0; c < 256; c++) begin
      wr(A_DATA, 32'h200 | 32'(c));
      expect_frame("R4 tx sweep", 8'(c));
      if (c < 4) begin
        rd(A_DATA, v); check("R3 slot free after launch", v, 32'h200);
      end
    end

    // R3: write with bit 9 clear launches nothing
    wr(A_DATA, 32'h0A5);
    expect_quiet("R3 no launch", 80);
    rd(A_DATA, v); check("R3 slot still empty", v, 32'h200);

    // R5: exhaustive receive sweep with acknowledge
    for (int c = 0; c < 256; c++) begin
      send_frame(8'(c), 1'b1);
      rd(A_DATA, v); check("R5 rx sweep", v, 32'h300 | 32'(c));
      wr(A_DATA, 32'h100);
      rd(A_DATA, v); check("R5 ack clears", v, 32'h200);
    end

    // R6: overrun keeps the first character and sets the sticky flag
    send_frame(8'hC3, 1'b1);
    send_frame(8'h3C, 1'b1);
    rd(A_DATA, v); check("R6 held char kept", v, 32'h3C3);
    rd(A_CTRL, v); check("R6 overrun set", v, RUN_CFG | 32'h10);
    wr(A_DATA, 32'h100);
    rd(A_CTRL, v); check("R6 overrun sticky after ack", v, RUN_CFG | 32'h10);
    wr(A_CTRL, RUN_CFG | 32'h10);
    rd(A_CTRL, v); check("R6 overrun cleared", v, RUN_CFG);

    // R10: bad stop bit discards the frame
    send_frame(8'h77, 1'b0);
    rd(A_DATA, v); check("R10 framing discard", v, 32'h200);

    // R7: mode 0 disables both shifters
    wr(A_CTRL, 32'h180);
    wr(A_DATA, 32'h23C);
    expect_quiet("R7 disabled tx", 80);
    rd(A_DATA, v); check("R7 char waits in slot", v, 32'h000);
    send_frame(8'h55, 1'b1);
    rd(A_DATA, v); check("R7 rx ignored", v, 32'h000);
    wr(A_CTRL, RUN_CFG);
    expect_frame("R7 waiting char sent on enable", 8'h3C);

    // R8: interface mode 1 routing
    wr(A_CTRL, 32'h004);
    hs_in = 2'b10;
    wr(A_DATA, 32'h296);
    expect_quiet("R8 mode1 tx gated", 80);
    rd(A_DATA, v); check("R8 mode1 tx held", v, 32'h000);
    hs_in = 2'b01;
    expect_frame("R8 mode1 tx released", 8'h96);
    send_frame(8'h11, 1'b1);
    rd(A_DATA, v); check("R8 mode1 rx gated", v, 32'h200);
    hs_in = 2'b10;
    send_frame(8'h22, 1'b1);
    rd(A_DATA, v); check("R8 mode1 rx open", v, 32'h322);
    wr(A_DATA, 32'h100);

    // R8: interface mode 2 routing
    wr(A_CTRL, 32'h008);
    hs_in = 2'b01;
    wr(A_DATA, 32'h244);
    expect_quiet("R8 mode2 tx gated", 80);
    rd(A_DATA, v); check("R8 mode2 tx held", v, 32'h000);
    hs_in = 2'b10;
    expect_frame("R8 mode2 tx released", 8'h44);
    send_frame(8'h33, 1'b1);
    rd(A_DATA, v); check("R8 mode2 rx gated", v, 32'h200);
    hs_in = 2'b01;
    send_frame(8'h66, 1'b1);
    rd(A_DATA, v); check("R8 mode2 rx open", v, 32'h366);
    wr(A_DATA, 32'h100);

    // R8: mode 3 routes like mode 2
    wr(A_CTRL, 32'h00C);
    hs_in = 2'b10;
    wr(A_DATA, 32'h25A);
    expect_frame("R8 mode3 tx", 8'h5A);

    // R9: override bits
    hs_in = 2'b00;
    wr(A_CTRL, 32'h088);
    wr(A_DATA, 32'h281);
    expect_frame("R9 tx override", 8'h81);
    wr(A_CTRL, 32'h108);
    send_frame(8'h42, 1'b1);
    rd(A_DATA, v); check("R9 rx override", v, 32'h342);
    wr(A_DATA, 32'h100);
    wr(A_DATA, 32'h218);
    expect_quiet("R9 tx still gated without its override", 80);
    rd(A_DATA, v); check("R9 tx held", v, 32'h000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule